// File: doc/BRIEF.md
# Buffered Disk Controller Bus Bridge

This block connects the register page of an emulated floppy disk controller on an 8-bit host bus (phase-2 clock, R/W strobe, page select) to a faster local microcontroller running on its own clock. The firmware loads sector bytes into a small asynchronous FIFO. The host polls a data-request register and pulls bytes from a data register. The hardware alone keeps the ready indication correct, so slow firmware never exposes a stale ready flag.

Host writes are latched when phase 2 falls and handed to the local clock domain through toggle-and-synchroniser handshakes. A byte that the firmware tags as the last of a sector raises the end-of-sector status and the interrupt only when the host actually takes that byte. The local side is interrupted when a command arrives, when the FIFO drains empty and at end of sector, not for every byte. A flush input discards queued bytes after an aborted transfer.

Top module: `fdc_bus_bridge`

## Requirements
- R1: Reading page offset 0x18 returns bit 7 = 0 while the FIFO holds a byte for the host and bit 7 = 1 when it is empty; all other bits read 0; after reset bit 7 is 1.
- R2: Reading offset 0x13 returns the FIFO head, and bytes come out in the order the local side loaded them; the byte is consumed when phase 2 falls.
- R3: Once the host has taken the last queued byte, its very next poll of offset 0x18 reads not-ready, with no action by the local side.
- R4: The host data bus is driven (h_oe = 1) only during a selected cycle with R/W high; unselected cycles and write cycles leave it released.
- R5: Reading offset 0x10 returns bit 7 = disk interrupt pending and bit 2 = end of sector, all other bits 0, and the read clears both, so an immediate second read returns 0x00.
- R6: End of sector is set only when the host takes the byte loaded with l_last = 1, not when that byte is loaded.
- R7: Bit 0 of the control register at offset 0x14 (written and read back by the host, reset 0) enables h_irq; h_irq is the pending interrupt gated by that bit.
- R8: A host write to offset 0x00 delivers the byte on l_cmd with l_cmd_valid = 1, which also drives l_irq, until l_cmd_ack clears it.
- R9: l_empty_irq sets when the FIFO drains to empty, stays 0 while bytes remain, and clears on l_irq_clr.
- R10: l_eos_irq sets once the host has taken a last-tagged byte and clears on l_irq_clr.
- R11: l_full is 1 when the FIFO holds its full depth (4 entries by default); a load while full is dropped.
- R12: A pulse on l_flush discards every queued byte; the host then reads not-ready, and later loads come out normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low synchronous reset for both domains |
| h_phi2 | input | 1 | Host phase-2 clock; host state updates on its falling edge |
| h_cs | input | 1 | Controller page selected |
| h_rw | input | 1 | Host R/W, 1 = read |
| h_addr | input | 8 | Offset within the controller page |
| h_din | input | 8 | Host write data |
| h_dout | output | 8 | Host read data |
| h_oe | output | 1 | Host data bus output enable |
| h_irq | output | 1 | Host disk interrupt, active high |
| l_clk | input | 1 | Local controller clock |
| l_push | input | 1 | Load l_byte into the FIFO |
| l_byte | input | 8 | Byte to load |
| l_last | input | 1 | Tags the loaded byte as last of a sector |
| l_flush | input | 1 | Discard FIFO contents |
| l_full | output | 1 | FIFO full |
| l_cmd | output | 8 | Last command byte written by the host |
| l_cmd_valid | output | 1 | Command pending |
| l_cmd_ack | input | 1 | Clears the pending command |
| l_empty_irq | output | 1 | FIFO drained to empty |
| l_eos_irq | output | 1 | Host took the last byte of a sector |
| l_irq_clr | input | 1 | Clears l_empty_irq and l_eos_irq |
| l_irq | output | 1 | Local interrupt, OR of the three local flags |

## Verification
The host taking the only queued byte and the firmware loading the next one can land in the same window, one on a phase-2 fall and the other on a local clock edge. The bench starts both at once, with the new byte tagged as last. It then requires that the poll shows ready again, that the bytes come out in load order, and that end of sector appears only after the second byte has been taken. A sweep over fill levels from one byte to full depth, with the interrupt enable alternating, covers the remaining flag interplay.

// File: rtl/bridge_pkg.sv
// Package bridge_pkg: register offsets within the controller page and
// the status bit positions shared by the bridge and its checker.
package bridge_pkg;
    localparam logic [7:0] OFF_CMD  = 8'h00;
    localparam logic [7:0] OFF_STAT = 8'h10;
    localparam logic [7:0] OFF_DATA = 8'h13;
    localparam logic [7:0] OFF_CTRL = 8'h14;
    localparam logic [7:0] OFF_DRQ  = 8'h18;
    localparam int STAT_PEND_BIT = 7;
    localparam int STAT_EOS_BIT  = 2;
    localparam int DRQ_BUSY_BIT  = 7;
endpackage

// File: rtl/bridge_evt_sync.sv
// Module bridge_evt_sync: carries an event, encoded as a level toggle in the
// source domain, into the destination clock and emits a one-cycle pulse.
// Assumes the source toggles no faster than STAGES+1 destination cycles.
module bridge_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES:0] sr;

    // Shift the toggle level through the synchroniser and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-1:0], tog_in};
    end

    assign pulse = sr[STAGES] ^ sr[STAGES-1];
endmodule

// File: rtl/bridge_fifo.sv
// Module bridge_fifo: asynchronous FIFO with Gray-coded pointers, written in
// the local domain and read in the host domain. Read data is the head entry,
// presented without a clock. A flush in the read domain moves the read
// pointer to the synchronised write pointer. Assumes AW >= 2.
module bridge_fifo #(
    parameter int DW     = 9,
    parameter int AW     = 2,
    parameter int STAGES = 2
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          w_en,
    input  logic [DW-1:0] w_data,
    output logic          w_full,
    output logic          w_empty,
    input  logic          rclk,
    input  logic          r_pop,
    input  logic          r_flush,
    output logic [DW-1:0] r_data,
    output logic          r_empty
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rg_sync [STAGES];
    logic [PW-1:0] wg_sync [STAGES];

    assign w_full  = (wgray == {~rg_sync[STAGES-1][PW-1:PW-2], rg_sync[STAGES-1][PW-3:0]});
    assign w_empty = (wgray == rg_sync[STAGES-1]);
    assign r_empty = (rgray == wg_sync[STAGES-1]);
    assign r_data  = mem[rbin[AW-1:0]];

    // Store an accepted entry.
    always_ff @(posedge wclk) begin
        if (w_en && !w_full) mem[wbin[AW-1:0]] <= w_data;
    end

    // Advance the write pointer on an accepted entry.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (w_en && !w_full) begin
            wbin  <= wbin + 1'b1;
            wgray <= b2g(wbin + 1'b1);
        end
    end

    // Bring the read pointer into the write domain.
    always_ff @(posedge wclk) begin
        if (!rst_n) for (int i = 0; i < STAGES; i++) rg_sync[i] <= '0;
        else begin
            rg_sync[0] <= rgray;
            for (int i = 1; i < STAGES; i++) rg_sync[i] <= rg_sync[i-1];
        end
    end

    // Bring the write pointer into the read domain.
    always_ff @(posedge rclk) begin
        if (!rst_n) for (int i = 0; i < STAGES; i++) wg_sync[i] <= '0;
        else begin
            wg_sync[0] <= wgray;
            for (int i = 1; i < STAGES; i++) wg_sync[i] <= wg_sync[i-1];
        end
    end

    // Advance the read pointer on a pop, or jump it to the write pointer on a flush.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (r_flush) begin
            rbin  <= g2b(wg_sync[STAGES-1]);
            rgray <= wg_sync[STAGES-1];
        end else if (r_pop && !r_empty) begin
            rbin  <= rbin + 1'b1;
            rgray <= b2g(rbin + 1'b1);
        end
    end
endmodule

// File: rtl/fdc_bus_bridge.sv
// Module fdc_bus_bridge: bridges a host register page (clocked by the falling
// edge of phase 2) to a local controller clock. Assumes the host presents
// address, select, R/W and write data before phase 2 falls, that phase 2 keeps
// running, and that the local side waits for l_empty_irq after a flush before
// loading new bytes.
module fdc_bus_bridge
    import bridge_pkg::*;
#(
    parameter int FIFO_AW     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       rst_n,
    input  logic       h_phi2,
    input  logic       h_cs,
    input  logic       h_rw,
    input  logic [7:0] h_addr,
    input  logic [7:0] h_din,
    output logic [7:0] h_dout,
    output logic       h_oe,
    output logic       h_irq,
    input  logic       l_clk,
    input  logic       l_push,
    input  logic [7:0] l_byte,
    input  logic       l_last,
    input  logic       l_flush,
    output logic       l_full,
    output logic [7:0] l_cmd,
    output logic       l_cmd_valid,
    input  logic       l_cmd_ack,
    output logic       l_empty_irq,
    output logic       l_eos_irq,
    input  logic       l_irq_clr,
    output logic       l_irq
);
    logic       h_clk;
    logic       h_rd, h_wr, rd_data, rd_stat, wr_cmd, wr_ctrl, h_pop;
    logic       h_empty, h_flush_p, head_last;
    logic [8:0] head;
    logic       ctrl_en, irq_pend, eos;
    logic [7:0] cmd_reg;
    logic       tog_cmd, tog_eos, tog_flush;
    logic       cmd_p, eos_p, w_empty, empty_q;

    assign h_clk     = ~h_phi2;
    assign h_rd      = h_cs & h_rw;
    assign h_wr      = h_cs & ~h_rw;
    assign rd_data   = h_rd && (h_addr == OFF_DATA);
    assign rd_stat   = h_rd && (h_addr == OFF_STAT);
    assign wr_cmd    = h_wr && (h_addr == OFF_CMD);
    assign wr_ctrl   = h_wr && (h_addr == OFF_CTRL);
    assign h_pop     = rd_data && !h_empty;
    assign head_last = head[8];

    bridge_fifo #(.DW(9), .AW(FIFO_AW), .STAGES(SYNC_STAGES)) u_fifo (
        .wclk(l_clk), .rst_n(rst_n), .w_en(l_push), .w_data({l_last, l_byte}),
        .w_full(l_full), .w_empty(w_empty),
        .rclk(h_clk), .r_pop(h_pop), .r_flush(h_flush_p),
        .r_data(head), .r_empty(h_empty)
    );

    bridge_evt_sync #(.STAGES(SYNC_STAGES)) u_cmd_sync (
        .clk(l_clk), .rst_n(rst_n), .tog_in(tog_cmd), .pulse(cmd_p));
    bridge_evt_sync #(.STAGES(SYNC_STAGES)) u_eos_sync (
        .clk(l_clk), .rst_n(rst_n), .tog_in(tog_eos), .pulse(eos_p));
    bridge_evt_sync #(.STAGES(SYNC_STAGES)) u_flush_sync (
        .clk(h_clk), .rst_n(rst_n), .tog_in(tog_flush), .pulse(h_flush_p));

    // Host-domain registers: control, command latch, status flags, event toggles.
    always_ff @(posedge h_clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            irq_pend <= 1'b0;
            eos      <= 1'b0;
            cmd_reg  <= '0;
            tog_cmd  <= 1'b0;
            tog_eos  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_en <= h_din[0];
            if (wr_cmd) begin
                cmd_reg <= h_din;
                tog_cmd <= ~tog_cmd;
            end
            if (rd_stat) begin
                irq_pend <= 1'b0;
                eos      <= 1'b0;
            end
            if (h_pop && head_last) begin
                irq_pend <= 1'b1;
                eos      <= 1'b1;
                tog_eos  <= ~tog_eos;
            end
        end
    end

    // Host read-data mux, valid for the whole selected read cycle.
    always_comb begin
        h_dout = '0;
        case (h_addr)
            OFF_DATA: h_dout = head[7:0];
            OFF_DRQ:  h_dout[DRQ_BUSY_BIT] = h_empty;
            OFF_STAT: begin
                h_dout[STAT_PEND_BIT] = irq_pend;
                h_dout[STAT_EOS_BIT]  = eos;
            end
            OFF_CTRL: h_dout[0] = ctrl_en;
            default:  h_dout = '0;
        endcase
    end

    assign h_oe  = h_rd;
    assign h_irq = irq_pend & ctrl_en;

    // Local-domain flags: command pending, drain and end-of-sector events, flush toggle.
    always_ff @(posedge l_clk) begin
        if (!rst_n) begin
            l_cmd       <= '0;
            l_cmd_valid <= 1'b0;
            l_empty_irq <= 1'b0;
            l_eos_irq   <= 1'b0;
            empty_q     <= 1'b1;
            tog_flush   <= 1'b0;
        end else begin
            empty_q <= w_empty;
            if (cmd_p) begin
                l_cmd       <= cmd_reg;
                l_cmd_valid <= 1'b1;
            end else if (l_cmd_ack) begin
                l_cmd_valid <= 1'b0;
            end
            if (w_empty && !empty_q) l_empty_irq <= 1'b1;
            else if (l_irq_clr)      l_empty_irq <= 1'b0;
            if (eos_p)               l_eos_irq <= 1'b1;
            else if (l_irq_clr)      l_eos_irq <= 1'b0;
            if (l_flush) tog_flush <= ~tog_flush;
        end
    end

    assign l_irq = l_cmd_valid | l_empty_irq | l_eos_irq;
endmodule

// File: rtl/fdc_bus_bridge_chk.sv
// Module fdc_bus_bridge_chk: temporal properties of the bridge, attached to
// every instance of the top module by the bind statement below.
module fdc_bus_bridge_chk #(
    parameter int PW = 3
) (
    input logic          h_clk,
    input logic          l_clk,
    input logic          rst_n,
    input logic          h_cs,
    input logic          h_oe,
    input logic          h_pop,
    input logic          head_last,
    input logic          rd_stat,
    input logic          eos,
    input logic          irq_pend,
    input logic          cmd_p,
    input logic          l_cmd_ack,
    input logic          l_cmd_valid,
    input logic          l_push,
    input logic          l_full,
    input logic [PW-1:0] wgray
);
    p_bus_release_r4: assert property (@(posedge l_clk) disable iff (!rst_n)
        !h_cs |-> !h_oe);

    p_eos_on_pop_r6: assert property (@(posedge h_clk) disable iff (!rst_n)
        $rose(eos) |-> $past(h_pop && head_last));

    p_stat_clear_r5: assert property (@(posedge h_clk) disable iff (!rst_n)
        rd_stat |=> !irq_pend && !eos);

    p_cmd_ack_r8: assert property (@(posedge l_clk) disable iff (!rst_n)
        (l_cmd_ack && !cmd_p) |=> !l_cmd_valid);

    p_no_overflow_r11: assert property (@(posedge l_clk) disable iff (!rst_n)
        (l_push && l_full) |=> $stable(wgray));
endmodule

bind fdc_bus_bridge fdc_bus_bridge_chk #(.PW(FIFO_AW + 1)) u_chk (
    .h_clk(h_clk), .l_clk(l_clk), .rst_n(rst_n), .h_cs(h_cs), .h_oe(h_oe),
    .h_pop(h_pop), .head_last(head_last), .rd_stat(rd_stat), .eos(eos),
    .irq_pend(irq_pend), .cmd_p(cmd_p), .l_cmd_ack(l_cmd_ack),
    .l_cmd_valid(l_cmd_valid), .l_push(l_push), .l_full(l_full),
    .wgray(u_fifo.wgray)
);

// File: tb/fdc_bus_bridge_tb_top.sv
module fdc_bus_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 23;
    localparam int DEPTH = 4;

    logic       rst_n = 0, h_phi2 = 0, h_cs = 0, h_rw = 1;
    logic [7:0] h_addr = 0, h_din = 0, h_dout;
    logic       h_oe, h_irq;
    logic       l_clk = 0, l_push = 0, l_last = 0, l_flush = 0, l_cmd_ack = 0, l_irq_clr = 0;
    logic [7:0] l_byte = 0, l_cmd;
    logic       l_full, l_cmd_valid, l_empty_irq, l_eos_irq, l_irq;
    int         n_chk = 0, n_fail = 0;
    logic [7:0] q;
    logic       oe;

    fdc_bus_bridge dut_i (.*);

    always #(CLK_PERIOD/2) l_clk = ~l_clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One host bus cycle: present, raise phase 2, sample mid-high, fall.
    task automatic hcyc(input logic cs, input logic rw, input logic [7:0] a, input logic [7:0] d);
        h_cs = cs; h_rw = rw; h_addr = a; h_din = d;
        #PH; h_phi2 = 1;
        #(PH/2); q = h_dout; oe = h_oe;
        #(PH - PH/2); h_phi2 = 0;
        #1; h_cs = 0; h_rw = 1;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) hcyc(0, 1, 8'h00, 8'h00);
    endtask

    task automatic lpush(input logic [7:0] b, input logic last);
        @(negedge l_clk); l_push = 1; l_byte = b; l_last = last;
        @(negedge l_clk); l_push = 0; l_last = 0;
    endtask

    task automatic lpulse_clr();
        @(negedge l_clk); l_irq_clr = 1;
        @(negedge l_clk); l_irq_clr = 0;
    endtask

    function automatic logic [7:0] val(input int n, input int i);
        return 8'((n * 37 + i * 11 + 5) & 255);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge l_clk); rst_n = 1;
        idle(2);
        // Reset state
        hcyc(1, 1, 8'h18, 0); chk("R1 reset drq", q, 8'h80);
        hcyc(1, 1, 8'h10, 0); chk("R5 reset status", q, 8'h00);
        hcyc(1, 1, 8'h14, 0); chk("R7 reset ctrl", q, 8'h00);
        chk("R7 reset irq", h_irq, 0);
        @(negedge l_clk); chk("R8 reset l_irq", l_irq, 0); chk("R11 reset full", l_full, 0);
        // Bus release
        hcyc(0, 1, 8'h13, 0); chk("R4 unselected oe", oe, 0);
        hcyc(1, 0, 8'h40, 0); chk("R4 write oe", oe, 0);
        hcyc(1, 1, 8'h40, 0); chk("R4 read oe", oe, 1);

        // Sweep fill levels 1..DEPTH, interrupt enable alternating
        for (int n = 1; n <= DEPTH; n++) begin
            hcyc(1, 0, 8'h14, 8'(n % 2));
            hcyc(1, 1, 8'h14, 0); chk("R7 ctrl readback", q, 8'(n % 2));
            for (int i = 0; i < n; i++) lpush(val(n, i), i == n - 1);
            if (n == DEPTH) begin @(negedge l_clk); chk("R11 full", l_full, 1); end
            idle(4);
            for (int i = 0; i < n; i++) begin
                hcyc(1, 1, 8'h18, 0); chk("R1 ready", q, 8'h00);
                if (i == n - 1) begin
                    hcyc(1, 1, 8'h10, 0); chk("R6 no eos before pop", q, 8'h00);
                    if (n > 1) begin @(negedge l_clk); chk("R9 no drain irq mid", l_empty_irq, 0); end
                end
                hcyc(1, 1, 8'h13, 0); chk("R2 data order", q, val(n, i));
            end
            hcyc(1, 1, 8'h18, 0); chk("R3 self clear", q, 8'h80);
            chk("R7 irq gate", h_irq, n % 2);
            idle(4);
            @(negedge l_clk);
            chk("R10 local eos", l_eos_irq, 1);
            chk("R9 drain irq", l_empty_irq, 1);
            hcyc(1, 1, 8'h10, 0); chk("R5 status", q, 8'h84);
            hcyc(1, 1, 8'h10, 0); chk("R5 status cleared", q, 8'h00);
            chk("R7 irq cleared", h_irq, 0);
            lpulse_clr();
            @(negedge l_clk); chk("R10 clr", l_eos_irq, 0); chk("R9 clr", l_empty_irq, 0);
        end

        // Overflow: one load beyond depth is dropped
        for (int i = 0; i <= DEPTH; i++) lpush(val(9, i), 0);
        @(negedge l_clk); chk("R11 full after overfill", l_full, 1);
        idle(4);
        for (int i = 0; i < DEPTH; i++) begin
            hcyc(1, 1, 8'h13, 0); chk("R11 kept data", q, val(9, i));
        end
        hcyc(1, 1, 8'h18, 0); chk("R11 extra dropped", q, 8'h80);
        idle(4); lpulse_clr();

        // Commands
        for (int k = 0; k < 4; k++) begin
            hcyc(1, 0, 8'h00, 8'(8'hA5 ^ (k * 8'h3C)));
            idle(2);
            @(negedge l_clk);
            chk("R8 cmd valid", l_cmd_valid, 1);
            chk("R8 cmd byte", l_cmd, 8'(8'hA5 ^ (k * 8'h3C)));
            chk("R8 l_irq", l_irq, 1);
            l_cmd_ack = 1; @(negedge l_clk); l_cmd_ack = 0;
            @(negedge l_clk); chk("R8 ack clears", l_cmd_valid, 0);
        end

        // Flush
        for (int i = 0; i < 3; i++) lpush(val(11, i), 0);
        idle(4);
        hcyc(1, 1, 8'h18, 0); chk("R12 ready before flush", q, 8'h00);
        @(negedge l_clk); l_flush = 1; @(negedge l_clk); l_flush = 0;
        idle(4);
        hcyc(1, 1, 8'h18, 0); chk("R12 flushed", q, 8'h80);
        lpulse_clr();
        lpush(8'h5A, 1);
        idle(4);
        hcyc(1, 1, 8'h13, 0); chk("R12 after flush data", q, 8'h5A);
        hcyc(1, 1, 8'h10, 0); chk("R12 after flush eos", q, 8'h84);
        idle(4); lpulse_clr();

        // Host pop and local load in the same window
        lpush(8'hC3, 0);
        idle(4);
        fork
            hcyc(1, 1, 8'h13, 0);
            lpush(8'h3C, 1);
        join
        chk("R2 concurrent first", q, 8'hC3);
        hcyc(1, 1, 8'h10, 0); chk("R6 concurrent no eos", q, 8'h00);
        idle(4);
        hcyc(1, 1, 8'h18, 0); chk("R1 concurrent ready", q, 8'h00);
        hcyc(1, 1, 8'h13, 0); chk("R2 concurrent second", q, 8'h3C);
        hcyc(1, 1, 8'h18, 0); chk("R3 concurrent clear", q, 8'h80);
        hcyc(1, 1, 8'h10, 0); chk("R6 concurrent eos", q, 8'h84);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule